// File: doc/BRIEF.md
# Controller interrupt status aggregator

This block builds the global interrupt status word of an audio-style bus controller from its sources and drives one level-sensitive interrupt line. The sources are a response-ring status register with two flags, a per-codec state-change register that is masked by a wake-enable register, and eight per-stream status registers. Hardware sources outside the block raise the flags with single-cycle set pulses. Software reads the registers and acknowledges flags through a small register bus, writing 1s to clear them.

The status word has three kinds of summary bit. Bits 0 to 7 are the per-stream summaries. Bit 30 is the controller summary. Bit 31 is the global summary. The word is recomputed every cycle from the stored flags. The interrupt line is formed from registered state only through gates, so a clear or a set shows on the line in the cycle after the edge that stores it.

Top module: `intr_status_agg`

## Requirements
- R1: After reset every status, control and enable register reads 0 and `irq_line` is low.
- R2: Bit i of the status word at address 1 equals bit 2 (buffer complete) of stream i's status register at address 8+i.
- R3: Bit 30 of the status word is 1 when response-status bit 0 (response flag) or bit 2 (overrun) is set, or when any codec-status bit is set and the same bit is set in the wake-enable register at address 2.
- R4: Bit 31 of the status word is 1 exactly when any of bits 30 to 0 is 1.
- R5: `irq_line` is 1 exactly when control bit 31 at address 0 is set and at least one of status bits 30 to 0 is set together with the control bit at the same position. The line reflects a register update one cycle after the write or pulse that causes it.
- R6: A pulse on `codec_evt[c]` sets bit c of the codec status at address 3 (15 codecs). Writing a 1 to a bit clears it, and writing a 0 leaves it unchanged.
- R7: In a stream status register, written 1s clear only bit 2 (buffer complete), bit 3 (FIFO error) and bit 4 (descriptor error). Bit 5 shows `strm_fifo_rdy[i]` sampled on the previous clock and is not changed by writes. All other bits read 0.
- R8: In the response status at address 4, written 1s clear only bit 0 and bit 2. All other bits read 0.
- R9: When a set pulse arrives in the same cycle as a write that clears the same bit, the bit ends set.
- R10: The FIFO-error and descriptor-error bits do not affect any summary bit or the line.
- R11: The control register keeps only bits 31, 30 and 7..0. The wake-enable register keeps bits 14..0. The status word at address 1 is read-only. Unmapped addresses read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register word address (write and read) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| codec_evt | input | 15 | Per-codec state-change set pulses |
| resp_flag_set | input | 1 | Sets the response flag |
| resp_ovf_set | input | 1 | Sets the response overrun flag |
| strm_bc_set | input | 8 | Per-stream buffer-complete set pulses |
| strm_ferr_set | input | 8 | Per-stream FIFO-error set pulses |
| strm_derr_set | input | 8 | Per-stream descriptor-error set pulses |
| strm_fifo_rdy | input | 8 | Per-stream FIFO-ready levels |
| irq_line | output | 1 | Level interrupt output |

## Verification
The bench goes after four kinds of mistake.

- Enable masks: for every stream it sweeps correct, wrong and missing enables. A design that checked the wrong enable bit, or ignored the global enable, would raise the line when it must stay low.
- Wake-enable gating: for every codec it tests the gating on its own. A design that left out the mask would raise the controller summary too early. A clear mask that was too wide would wipe the FIFO-ready bit or let the error bits drive the summary.
- Response clearing: all eight write patterns on the response status expose a mask that clears the wrong flag.
- Set-versus-clear collision: a design that lets the clear win loses an event.

// File: rtl/intagg_pkg.sv
package intagg_pkg;
    localparam int DW      = 32;
    localparam int GIS_BIT = DW - 1;
    localparam int CIS_BIT = DW - 2;

    localparam int A_CTL   = 0;
    localparam int A_STS   = 1;
    localparam int A_WAKE  = 2;
    localparam int A_CODEC = 3;
    localparam int A_RESP  = 4;
    localparam int A_STRM0 = 8;

    localparam int RESP_W  = 3;
    localparam logic [RESP_W-1:0] RESP_CLR = 3'b101;

    localparam int SSTS_W  = 5;
    localparam int BC_BIT  = 2;
    localparam int FE_BIT  = 3;
    localparam int DE_BIT  = 4;
    localparam int RDY_BIT = 5;
    localparam logic [SSTS_W-1:0] SSTS_CLR = 5'b11100;
endpackage

// File: rtl/w1c_reg.sv
module w1c_reg #(
    parameter int W = 8,
    parameter logic [W-1:0] CLR_MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] q;
    logic [W-1:0] clr;
    logic [W-1:0] q_d;

    always_comb begin
        clr = wr_i ? (wdata_i & CLR_MASK) : '0;
        q_d = (q & ~clr) | set_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= q_d;
    end

    assign q_o = q;

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((q & $past(set_i)) == $past(set_i)));

    // R6
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && set_i == '0) |=> ((q & $past(wdata_i & CLR_MASK)) == '0));

    // R8
    keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_i & ~CLR_MASK) == '0) |=> ((q & ~CLR_MASK) == $past(q & ~CLR_MASK)));
endmodule

// File: rtl/strm_status_bank.sv
module strm_status_bank
    import intagg_pkg::*;
#(
    parameter int NS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NS-1:0]        wr_sel,
    input  logic [SSTS_W-1:0]    wdata,
    input  logic [NS-1:0]        bc_set,
    input  logic [NS-1:0]        ferr_set,
    input  logic [NS-1:0]        derr_set,
    input  logic [NS-1:0]        fifo_rdy,
    output logic [NS-1:0][7:0]   sts_o,
    output logic [NS-1:0]        bc_o
);
    logic [NS-1:0] rdy_q;

    always_ff @(posedge clk) begin
        if (!rst_n) rdy_q <= '0;
        else        rdy_q <= fifo_rdy;
    end

    for (genvar i = 0; i < NS; i++) begin : g_strm
        logic [SSTS_W-1:0] set_v;
        logic [SSTS_W-1:0] q;

        always_comb begin
            set_v = '0;
            set_v[BC_BIT] = bc_set[i];
            set_v[FE_BIT] = ferr_set[i];
            set_v[DE_BIT] = derr_set[i];
        end

        w1c_reg #(.W(SSTS_W), .CLR_MASK(SSTS_CLR)) u_sts (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_i   (set_v),
            .wr_i    (wr_sel[i]),
            .wdata_i (wdata),
            .q_o     (q)
        );

        always_comb begin
            sts_o[i]          = '0;
            sts_o[i][SSTS_W-1:0] = q;
            sts_o[i][RDY_BIT] = rdy_q[i];
        end
        assign bc_o[i] = q[BC_BIT];

        // R7
        rdy_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (sts_o[i][RDY_BIT] == $past(fifo_rdy[i])));
    end
endmodule

// File: rtl/intr_summary.sv
module intr_summary
    import intagg_pkg::*;
#(
    parameter int NS = 8,
    parameter int NC = 15
) (
    input  logic [RESP_W-1:0] resp_sts,
    input  logic [NC-1:0]     codec_sts,
    input  logic [NC-1:0]     wake_en,
    input  logic [NS-1:0]     strm_bc,
    input  logic [DW-1:0]     ctl,
    output logic [DW-1:0]     sts_word,
    output logic              irq
);
    for (genvar g = 0; g < CIS_BIT; g++) begin : g_sis
        if (g < NS) begin : g_used
            assign sts_word[g] = strm_bc[g];
        end else begin : g_pad
            assign sts_word[g] = 1'b0;
        end
    end

    assign sts_word[CIS_BIT] = resp_sts[0] | resp_sts[2] | (|(codec_sts & wake_en));
    assign sts_word[GIS_BIT] = |sts_word[CIS_BIT:0];
    assign irq = ctl[GIS_BIT] && (|(sts_word[CIS_BIT:0] & ctl[CIS_BIT:0]));

    // R4
    always_comb begin
        gis_consistent_chk: assert (sts_word[GIS_BIT] || !irq);
    end
endmodule

// File: rtl/intr_status_agg.sv
module intr_status_agg
    import intagg_pkg::*;
#(
    parameter int NUM_STREAMS = 8,
    parameter int NUM_CODECS  = 15,
    parameter int ADDR_W      = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_wr,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [DW-1:0]          bus_wdata,
    output logic [DW-1:0]          bus_rdata,
    input  logic [NUM_CODECS-1:0]  codec_evt,
    input  logic                   resp_flag_set,
    input  logic                   resp_ovf_set,
    input  logic [NUM_STREAMS-1:0] strm_bc_set,
    input  logic [NUM_STREAMS-1:0] strm_ferr_set,
    input  logic [NUM_STREAMS-1:0] strm_derr_set,
    input  logic [NUM_STREAMS-1:0] strm_fifo_rdy,
    output logic                   irq_line
);
    localparam logic [DW-1:0] CTL_KEEP =
        (DW'(1) << GIS_BIT) | (DW'(1) << CIS_BIT) | ((DW'(1) << NUM_STREAMS) - DW'(1));

    logic [DW-1:0]               ctl_q;
    logic [NUM_CODECS-1:0]       wake_q;
    logic [NUM_CODECS-1:0]       codec_q;
    logic [RESP_W-1:0]           resp_q;
    logic [RESP_W-1:0]           resp_set;
    logic [NUM_STREAMS-1:0]      strm_wr;
    logic [NUM_STREAMS-1:0][7:0] strm_sts;
    logic [NUM_STREAMS-1:0]      strm_bc;
    logic [DW-1:0]               int_sts;
    logic                        wr_ctl, wr_wake, wr_codec, wr_resp;

    assign wr_ctl   = bus_wr && (bus_addr == ADDR_W'(A_CTL));
    assign wr_wake  = bus_wr && (bus_addr == ADDR_W'(A_WAKE));
    assign wr_codec = bus_wr && (bus_addr == ADDR_W'(A_CODEC));
    assign wr_resp  = bus_wr && (bus_addr == ADDR_W'(A_RESP));

    for (genvar i = 0; i < NUM_STREAMS; i++) begin : g_wdec
        assign strm_wr[i] = bus_wr && (bus_addr == ADDR_W'(A_STRM0 + i));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            wake_q <= '0;
        end else begin
            if (wr_ctl)  ctl_q  <= bus_wdata & CTL_KEEP;
            if (wr_wake) wake_q <= bus_wdata[NUM_CODECS-1:0];
        end
    end

    w1c_reg #(.W(NUM_CODECS), .CLR_MASK({NUM_CODECS{1'b1}})) u_codec (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (codec_evt),
        .wr_i    (wr_codec),
        .wdata_i (bus_wdata[NUM_CODECS-1:0]),
        .q_o     (codec_q)
    );

    assign resp_set = {resp_ovf_set, 1'b0, resp_flag_set};

    w1c_reg #(.W(RESP_W), .CLR_MASK(RESP_CLR)) u_resp (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (resp_set),
        .wr_i    (wr_resp),
        .wdata_i (bus_wdata[RESP_W-1:0]),
        .q_o     (resp_q)
    );

    strm_status_bank #(.NS(NUM_STREAMS)) u_strm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_sel   (strm_wr),
        .wdata    (bus_wdata[SSTS_W-1:0]),
        .bc_set   (strm_bc_set),
        .ferr_set (strm_ferr_set),
        .derr_set (strm_derr_set),
        .fifo_rdy (strm_fifo_rdy),
        .sts_o    (strm_sts),
        .bc_o     (strm_bc)
    );

    intr_summary #(.NS(NUM_STREAMS), .NC(NUM_CODECS)) u_sum (
        .resp_sts  (resp_q),
        .codec_sts (codec_q),
        .wake_en   (wake_q),
        .strm_bc   (strm_bc),
        .ctl       (ctl_q),
        .sts_word  (int_sts),
        .irq       (irq_line)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(A_CTL):   bus_rdata = ctl_q;
            ADDR_W'(A_STS):   bus_rdata = int_sts;
            ADDR_W'(A_WAKE):  bus_rdata = DW'(wake_q);
            ADDR_W'(A_CODEC): bus_rdata = DW'(codec_q);
            ADDR_W'(A_RESP):  bus_rdata = DW'(resp_q);
            default:          bus_rdata = '0;
        endcase
        for (int i = 0; i < NUM_STREAMS; i++) begin
            if (bus_addr == ADDR_W'(A_STRM0 + i)) bus_rdata = DW'(strm_sts[i]);
        end
    end

    // R5
    gie_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && !bus_wdata[GIS_BIT]) |=> !irq_line);

    // R3
    cis_from_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_flag_set || resp_ovf_set) |=> int_sts[CIS_BIT]);

    // R4
    gis_on_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_line |-> int_sts[GIS_BIT]);

    for (genvar i = 0; i < NUM_STREAMS; i++) begin : g_sis_chk
        // R2
        sis_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            strm_bc_set[i] |=> int_sts[i]);
    end
endmodule

// File: tb/tb_intr_status_agg.sv
`timescale 1ns/1ps
module tb_intr_status_agg;
    localparam int NS = 8;
    localparam int NC = 15;
    localparam logic [31:0] GIE = 32'h8000_0000;
    localparam logic [31:0] CIS = 32'h4000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NC-1:0] codec_evt = '0;
    logic        resp_flag_set = 1'b0;
    logic        resp_ovf_set = 1'b0;
    logic [NS-1:0] strm_bc_set = '0;
    logic [NS-1:0] strm_ferr_set = '0;
    logic [NS-1:0] strm_derr_set = '0;
    logic [NS-1:0] strm_fifo_rdy = '0;
    logic        irq_line;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    intr_status_agg dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .codec_evt(codec_evt),
        .resp_flag_set(resp_flag_set), .resp_ovf_set(resp_ovf_set),
        .strm_bc_set(strm_bc_set), .strm_ferr_set(strm_ferr_set),
        .strm_derr_set(strm_derr_set), .strm_fifo_rdy(strm_fifo_rdy),
        .irq_line(irq_line)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 5'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = 5'(a);
        #1 v = bus_rdata;
    endtask

    task automatic chk_irq(input string req, input logic exp);
        @(negedge clk);
        #1 chk(req, 32'(irq_line), 32'(exp));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [7:0]  rdy;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 16; a++) begin
            rd(a, v);
            chk("R1 reset reg", v, 32'h0);
        end
        chk_irq("R1 reset line", 1'b0);

        // R11 register map
        wr(0, 32'hFFFF_FFFF); rd(0, v); chk("R11 ctl keep", v, 32'hC000_00FF);
        wr(2, 32'hFFFF_FFFF); rd(2, v); chk("R11 wake keep", v, 32'h0000_7FFF);
        wr(2, 0);
        wr(1, 32'hFFFF_FFFF); rd(1, v); chk("R11 sts read-only", v, 32'h0);
        wr(5, 32'hFFFF_FFFF); rd(5, v); chk("R11 unmapped", v, 32'h0);
        rd(31, v); chk("R11 unmapped high", v, 32'h0);

        // R2 R4 R5 stream sweep
        for (int i = 0; i < NS; i++) begin
            wr(0, GIE | (32'h1 << i));
            @(negedge clk); strm_bc_set = 8'(1 << i);
            @(negedge clk); strm_bc_set = '0;
            rd(1, v); chk("R2 R4 stream summary", v, GIE | (32'h1 << i));
            rd(8 + i, v); chk("R2 stream bc bit", v, 32'h4);
            chk_irq("R5 enabled line", 1'b1);
            wr(0, 32'h1 << i); chk_irq("R5 no global enable", 1'b0);
            wr(0, GIE | (32'h1 << ((i + 1) % NS))); chk_irq("R5 wrong stream enable", 1'b0);
            wr(0, GIE | CIS); chk_irq("R5 only controller enable", 1'b0);
            wr(0, GIE | (32'h1 << i)); chk_irq("R5 reenabled", 1'b1);
            wr(8 + i, 32'h4);
            rd(1, v); chk("R7 bc cleared", v, 32'h0);
            chk_irq("R5 line after clear", 1'b0);
        end

        // R10 R7 error bits and ready bit
        wr(0, GIE | 32'hFF);
        rdy = 8'hA5;
        @(negedge clk); strm_fifo_rdy = rdy; strm_ferr_set = '1; strm_derr_set = '1;
        @(negedge clk); strm_ferr_set = '0; strm_derr_set = '0;
        rd(1, v); chk("R10 errors no summary", v, 32'h0);
        chk_irq("R10 errors no line", 1'b0);
        for (int j = 0; j < NS; j++) begin
            rd(8 + j, v); chk("R7 error bits set", v, 32'h18 | (32'(rdy[j]) << 5));
            wr(8 + j, 32'hFFFF_FFFF);
            rd(8 + j, v); chk("R7 only ready kept", v, 32'(rdy[j]) << 5);
        end

        // R6 R3 codec sweep
        wr(0, GIE | CIS);
        for (int c = 0; c < NC; c++) begin
            wr(2, 0);
            @(negedge clk); codec_evt = 15'(1 << c);
            @(negedge clk); codec_evt = '0;
            rd(3, v); chk("R6 codec set", v, 32'h1 << c);
            rd(1, v); chk("R3 unmasked codec", v, 32'h0);
            wr(2, 32'h1 << c);
            rd(1, v); chk("R3 wake enabled", v, GIE | CIS);
            chk_irq("R5 codec line", 1'b1);
            wr(3, ~(32'h1 << c)); rd(3, v); chk("R6 zero write keeps", v, 32'h1 << c);
            wr(3, 32'h1 << c); rd(3, v); chk("R6 w1c", v, 32'h0);
            chk_irq("R6 line after clear", 1'b0);
        end

        // R8 R3 response clear sweep
        for (int p = 0; p < 8; p++) begin
            @(negedge clk); resp_flag_set = 1'b1; resp_ovf_set = 1'b1;
            @(negedge clk); resp_flag_set = 1'b0; resp_ovf_set = 1'b0;
            rd(4, v); chk("R8 both set", v, 32'h5);
            wr(4, 32'(p));
            rd(4, v); chk("R8 partial clear", v, 32'(5 & ~p));
            rd(1, v); chk("R3 response summary", v, ((5 & ~p) != 0) ? (GIE | CIS) : 32'h0);
            wr(4, 32'h7);
        end

        // R9 set wins over simultaneous clear
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 5'd8; bus_wdata = 32'h4; strm_bc_set = 8'h01;
        @(negedge clk);
        bus_wr = 1'b0; strm_bc_set = '0;
        rd(8, v); chk("R9 set wins", v & 32'h1F, 32'h4);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 5'd3; bus_wdata = 32'h1; codec_evt = 15'h1;
        @(negedge clk);
        bus_wr = 1'b0; codec_evt = '0;
        rd(3, v); chk("R9 codec set wins", v, 32'h1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule